// File: doc/BRIEF.md
# Multi-mode UART baud rate generator

This block derives all bit-rate timing for a serial port from the system clock and a 12-bit divisor. A down-counter reloads from the divisor and fires a one-cycle prescaler strobe every (divisor+1) clocks. A second counter divides that strobe by a factor chosen by the operating mode to form a one-cycle transmit bit enable. The factor is 16 in asynchronous normal mode, 8 in asynchronous double-speed mode and 2 in synchronous master mode.

The prescaler strobe is also exported as the receiver's oversampling tick. A separate output reports how many samples the receiver takes per bit in the active mode. In synchronous master mode the block drives a serial clock with a 50% duty cycle at the bit rate. A divisor write, a change of effective mode, or deasserting the enable restarts both counters, so no partial period from the old setting survives.

Top module: `baud_rate_gen`

## Requirements
- R1: `presc_tick` pulses once every (D+1) clock cycles, where D is the written divisor (0..4095). D=0 gives a pulse on every cycle.
- R2: With `sync_mode`=0 and `dbl_speed`=0, successive `tx_bit_en` pulses are 16*(D+1) cycles apart.
- R3: With `sync_mode`=0 and `dbl_speed`=1, successive `tx_bit_en` pulses are 8*(D+1) cycles apart.
- R4: With `sync_mode`=1, successive `tx_bit_en` pulses are 2*(D+1) cycles apart.
- R5: While `sync_mode`=1, toggling `dbl_speed` changes no interval, causes no restart and leaves `samples_per_bit` at 2.
- R6: `samples_per_bit` reads 16, 8 or 2 for normal, double-speed and synchronous mode, one cycle after the mode inputs settle. `rx_os_tick` equals `presc_tick` on every cycle.
- R7: A `div_wr` pulse or a change of effective mode restarts both counters. `presc_tick` is low in the cycle after the restart edge. The first `tx_bit_en` appears F*(D+1) edges after the restart edge, where F is the mode factor. This holds even when the write lands on a prescaler wrap.
- R8: In synchronous mode `sclk_out` toggles on each prescaler wrap, so it stays high for exactly D+1 cycles. In asynchronous mode `sclk_out` is held low.
- R9: While `en`=0, no tick of any kind is produced. After `en` rises, the first `tx_bit_en` follows after F*(D+1) edges, counted from the first enabled edge as 1.
- R10: After reset all strobes and `sclk_out` are 0, the divisor is 0, and `samples_per_bit` is 16.
- R11: `tx_bit_en` is only ever high in a cycle where `presc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds counters at reload |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | DIV_W | Divisor value written on `div_wr` |
| sync_mode | input | 1 | 1 selects synchronous master mode |
| dbl_speed | input | 1 | Asynchronous double-speed select |
| presc_tick | output | 1 | Prescaler strobe, one cycle every D+1 |
| rx_os_tick | output | 1 | Receiver oversampling strobe |
| tx_bit_en | output | 1 | Transmit bit-clock enable |
| sclk_out | output | 1 | Synchronous serial clock |
| samples_per_bit | output | 5 | Receiver samples per bit in the active mode |

## Verification
A restart, whether from a divisor write or a mode change, can fall in the same cycle as a prescaler wrap that would otherwise emit a tick or a bit enable. The bench provokes this by running with divisor 0, where every cycle is a wrap, and then writing a new divisor and mode. It expects the restart to win: no tick in the following cycle, and a first bit enable exactly F*(D+1) edges later. A second overlap, a `dbl_speed` toggle in the middle of a synchronous bit period, is judged by requiring the straddling interval to remain 2*(D+1).

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC_N = 2'd0,
    MODE_ASYNC_D = 2'd1,
    MODE_SYNC    = 2'd2
  } baud_mode_e;

  localparam int FAC_W = 5;

  function automatic logic [FAC_W-1:0] mode_factor(baud_mode_e m);
    case (m)
      MODE_ASYNC_D: return FAC_W'(8);
      MODE_SYNC:    return FAC_W'(2);
      default:      return FAC_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/baud_presc.sv
module baud_presc #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt == '0)  cnt <= load_val;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = !load && (cnt == '0);
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  baud_mode_e mode,
  input  logic       tick,
  output logic       bit_en,
  output logic       sclk
);
  logic [FAC_W-1:0] bcnt;
  logic [FAC_W-1:0] top_val;

  assign top_val = mode_factor(mode) - FAC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)              bcnt <= FAC_W'(15);
    else if (load)        bcnt <= top_val;
    else if (tick) begin
      if (bcnt == '0)     bcnt <= top_val;
      else                bcnt <= bcnt - 1'b1;
    end
  end

  assign bit_en = tick && (bcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || load)                     sclk <= 1'b0;
    else if (tick && mode == MODE_SYNC)  sclk <= ~sclk;
  end
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sync_mode,
  input  logic             dbl_speed,
  output logic             presc_tick,
  output logic             rx_os_tick,
  output logic             tx_bit_en,
  output logic             sclk_out,
  output logic [FAC_W-1:0] samples_per_bit
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] load_val;
  baud_mode_e       eff_mode;
  baud_mode_e       mode_q;
  logic             mode_chg;
  logic             restart;
  logic             tick_raw;
  logic             bit_raw;

  // Double-speed only matters outside synchronous mode.
  always_comb begin
    if (sync_mode)      eff_mode = MODE_SYNC;
    else if (dbl_speed) eff_mode = MODE_ASYNC_D;
    else                eff_mode = MODE_ASYNC_N;
  end

  assign mode_chg = (eff_mode != mode_q);
  assign restart  = div_wr || mode_chg || !en;
  assign load_val = div_wr ? div_val : div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      mode_q <= MODE_ASYNC_N;
    end else begin
      if (div_wr) div_q <= div_val;
      mode_q <= eff_mode;
    end
  end

  baud_presc #(.DIV_W(DIV_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .load     (restart),
    .load_val (load_val),
    .tick     (tick_raw)
  );

  baud_bitdiv u_bitdiv (
    .clk    (clk),
    .rst    (rst),
    .load   (restart),
    .mode   (eff_mode),
    .tick   (tick_raw),
    .bit_en (bit_raw),
    .sclk   (sclk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_tick      <= 1'b0;
      rx_os_tick      <= 1'b0;
      tx_bit_en       <= 1'b0;
      samples_per_bit <= FAC_W'(16);
    end else begin
      presc_tick      <= tick_raw;
      rx_os_tick      <= tick_raw;
      tx_bit_en       <= bit_raw;
      samples_per_bit <= mode_factor(eff_mode);
    end
  end
endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             div_wr,
  input logic [DIV_W-1:0] div_val,
  input logic             sync_mode,
  input logic             dbl_speed,
  input logic             presc_tick,
  input logic             rx_os_tick,
  input logic             tx_bit_en,
  input logic             sclk_out,
  input logic [4:0]       samples_per_bit
);
  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tx_bit_en |-> presc_tick);                                   // R11
  AST_WR_RESTART: assert property (@(posedge clk) disable iff (rst)
    $past(div_wr) |-> !presc_tick && !tx_bit_en);                // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> !presc_tick && !rx_os_tick && !tx_bit_en);    // R9
  AST_SCLK_ASYNC_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(!sync_mode) |-> !sclk_out);                            // R8
  AST_SPB_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $countones(samples_per_bit) == 1 && samples_per_bit >= 5'd2); // R6
endmodule

bind baud_rate_gen baud_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        div_wr = 1'b0;
  logic [11:0] div_val = '0;
  logic        sync_mode = 1'b0;
  logic        dbl_speed = 1'b0;
  logic        presc_tick, rx_os_tick, tx_bit_en, sclk_out;
  logic [4:0]  samples_per_bit;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  baud_rate_gen #(.DIV_W(12)) i_baud_rate_gen (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fac(input bit s, input bit d);
    return s ? 2 : (d ? 8 : 16);
  endfunction

  function automatic string rtag(input bit s, input bit d);
    return s ? "R4" : (d ? "R3" : "R2");
  endfunction

  // counts negedges until tx_bit_en seen; first negedge counts as 1
  task automatic wait_tx(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      chk(rx_os_tick == presc_tick, "R6 rx_os_tick vs presc_tick", rx_os_tick, presc_tick);
      if (tx_bit_en || n > 70000) break;
    end
  endtask

  task automatic wait_presc(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (presc_tick || n > 5000) break;
    end
  endtask

  task automatic run_cfg(input int d, input bit s, input bit db, input int nint);
    int n;
    int e;
    e = fac(s, db) * (d + 1);
    @(negedge clk);
    div_val = 12'(d); div_wr = 1'b1; sync_mode = s; dbl_speed = db;
    @(negedge clk);
    div_wr = 1'b0;
    chk(presc_tick == 1'b0, "R7 tick after restart", presc_tick, 0);
    chk(samples_per_bit == 5'(fac(s, db)), "R6 samples_per_bit",
        samples_per_bit, fac(s, db));
    wait_tx(n);
    chk(n == e, "R7 first bit enable latency", n, e);
    for (int i = 0; i < nint; i++) begin
      wait_tx(n);
      chk(n == e, rtag(s, db), n, e);
    end
    wait_presc(n);
    wait_presc(n);
    chk(n == d + 1, "R1 prescaler interval", n, d + 1);
  endtask

  initial begin
    int n;
    int hi;
    int cnt;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(presc_tick == 0 && tx_bit_en == 0 && rx_os_tick == 0 && sclk_out == 0,
        "R10 strobes in reset", {presc_tick, tx_bit_en, rx_os_tick, sclk_out}, 0);
    chk(samples_per_bit == 5'd16, "R10 samples_per_bit", samples_per_bit, 16);
    rst = 1'b0;
    // R10: divisor resets to 0 -> tick every cycle
    @(negedge clk);
    wait_presc(n);
    wait_presc(n);
    chk(n == 1, "R10 R1 reset divisor 0", n, 1);

    // directed corners in every mode
    run_cfg(0, 0, 0, 2);
    run_cfg(0, 0, 1, 2);
    run_cfg(0, 1, 0, 2);
    run_cfg(4095, 1, 0, 1);
    run_cfg(7, 0, 0, 2);
    run_cfg(7, 0, 1, 2);

    // R7 collision: write lands on a wrap (divisor 0 wraps every cycle)
    run_cfg(0, 0, 0, 1);
    repeat (5) @(negedge clk);
    run_cfg(3, 0, 0, 1);
    // R7 collision via mode change alone
    run_cfg(0, 0, 1, 1);
    @(negedge clk);
    sync_mode = 1'b1;
    @(negedge clk);
    chk(presc_tick == 0, "R7 tick after mode change", presc_tick, 0);
    wait_tx(n);
    chk(n == 2, "R7 mode change latency", n, 2);

    // R5: dbl_speed toggle in sync mode mid-period
    run_cfg(20, 1, 0, 1);
    wait_tx(n);
    repeat (10) @(negedge clk);
    dbl_speed = 1'b1;
    wait_tx(n);
    chk(n + 10 == 42, "R5 interval across dbl toggle", n + 10, 42);
    chk(samples_per_bit == 5'd2, "R5 samples_per_bit stays", samples_per_bit, 2);
    wait_tx(n);
    chk(n == 42, "R5 interval after toggle", n, 42);
    dbl_speed = 1'b0;

    // R8: serial clock high time in sync mode
    run_cfg(5, 1, 0, 1);
    while (sclk_out) @(negedge clk);
    while (!sclk_out) @(negedge clk);
    hi = 0;
    while (sclk_out && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 6, "R8 sclk high time", hi, 6);
    run_cfg(2, 0, 0, 1);
    cnt = 0;
    repeat (60) begin @(negedge clk); if (sclk_out) cnt++; end
    chk(cnt == 0, "R8 sclk low in async", cnt, 0);

    // R9: enable low
    run_cfg(1, 0, 1, 1);
    en = 1'b0;
    @(negedge clk);
    cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (presc_tick || rx_os_tick || tx_bit_en) cnt++;
    end
    chk(cnt == 0, "R9 no ticks while disabled", cnt, 0);
    en = 1'b1;
    wait_tx(n);
    chk(n == 16, "R9 latency after enable", n, 16);
    wait_tx(n);
    chk(n == 16, "R9 R3 interval after enable", n, 16);

    // constrained random configurations
    for (int k = 0; k < 12; k++) begin
      int m;
      int d;
      m = int'($urandom % 3);
      d = int'($urandom % 48);
      run_cfg(d, m == 2, m == 1, 2);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule